// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Front End

This block models a synchronous pipelined SRAM whose interface moves two data words per command. Everything runs in one clock domain. Each clock cycle carries one command slot, made of a load strobe, a read/write select and an address. Each cycle also carries two data phases, the rising-half word and the falling-half word, presented side by side as an even and an odd word. The storage is two banks of words, one even and one odd, sharing a row index. A one-bit burst counter picks which bank is touched first.

A write places its two words on the data inputs in the cycle after its command, with active-low byte selects for each word. The block does not put that data into the array at once. It parks the address, data and byte enables in a posted-write register and commits them only when the next write's data arrives. Reads look through three layers, newest first: the write data arriving in the current cycle, then the posted register, then the array. A read therefore always returns the newest bytes. A strap input selects when read data is delivered: 1 cycle after the command, or 1.5 cycles after it. Each output word carries its own valid flag.

Top module: `ddr2b_sram`

## Requirements
- R1: A command is taken only in a cycle with `ldN`=0. If `rwN`=1 it is a read, and if `rwN`=0 it is a write. In a cycle with `ldN`=1 the other command inputs and the data inputs have no effect on the outputs or on the stored contents.
- R2: With `lat15Mode`=0, a read issued in cycle t drives word 0 on `qEven` and word 1 on `qOdd` in cycle t+1, and both valid flags are 1 in that cycle.
- R3: With `lat15Mode`=1, a read issued in cycle t drives word 0 on `qOdd` in cycle t+1 with only `qOddValid` set, then word 1 on `qEven` in cycle t+2 with `qEvenValid` set.
- R4: A read may be issued in every cycle and every word of every read is delivered. In the 1.5-cycle mode, word 1 of the older read and word 0 of the newer read share one cycle.
- R5: A write issued in cycle t takes word 0 from `dEven` and word 1 from `dOdd`, both during cycle t+1.
- R6: With the default `LSB_IN`=1, `addr[0]` is the burst start and the upper bits are the row. Word 0 goes to bank `addr[0]` of the row and word 1 to the other bank of the same row, so the burst wraps inside the pair.
- R7: With `LSB_IN`=0 the whole address is the row and word 0 always goes to the even bank.
- R8: Byte k of a word is bits [k*BYTE_W+BYTE_W-1 : k*BYTE_W]. Bit k of `bwEvenN` or `bwOddN` is active low: 0 writes byte k of that word, and 1 leaves the stored byte unchanged.
- R9: A read returns the newest contents, byte by byte. This includes a read issued in the cycle right after a write to the same row, while that write's data is still arriving. It also includes a read of a row whose partial write is still held in the posted register.
- R10: From reset, and in any output slot that carries no read word, the slot's data is 0 and its valid flag is 0. The array starts all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands and data phases are taken on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lat15Mode | input | 1 | Strap: 1 selects 1.5-cycle read latency, 0 selects 1-cycle latency |
| ldN | input | 1 | Command strobe, active low |
| rwN | input | 1 | 1 = read, 0 = write, when `ldN` is 0 |
| addr | input | ROW_W+LSB_IN | Row address, with the burst start bit at bit 0 when LSB_IN=1 |
| dEven | input | WORD_W | Write word 0, during the cycle after a write command |
| dOdd | input | WORD_W | Write word 1, during the cycle after a write command |
| bwEvenN | input | WORD_W/BYTE_W | Active-low byte selects for `dEven` |
| bwOddN | input | WORD_W/BYTE_W | Active-low byte selects for `dOdd` |
| qEven | output | WORD_W | Rising-half read word |
| qOdd | output | WORD_W | Falling-half read word |
| qEvenValid | output | 1 | `qEven` carries a read word |
| qOddValid | output | 1 | `qOdd` carries a read word |

## Verification
The assertions watch four things on every cycle. Each read command must produce the right output slot selections one or two cycles later, depending on the latency mode. Every write command must be followed by a data-capture cycle. A filled output slot must trace back to a read. The posted-write register may change only in capture cycles and stays filled once filled. Only the bench scenarios can show the data values themselves: burst order and wrap, byte-select merging, forwarding from the in-flight write and from the posted register, reads that overlap in the 1.5-cycle mode, and the narrow addressing variant.

// File: rtl/ddr2b_pkg.sv
`timescale 1ns/1ps
package ddr2b_pkg;
  // Source of one output slot
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_CUR_W0  = 2'd1,
    SRC_CUR_W1  = 2'd2,
    SRC_PREV_W1 = 2'd3
  } slotSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     rdLook;     // read command this cycle: latch looked-up pair
    logic     wrCapture;  // write data present this cycle
    slotSrc_e evenSrc;
    slotSrc_e oddSrc;
  } ctrlStrb_t;
endpackage

// File: rtl/ddr2b_ctrl.sv
`timescale 1ns/1ps
module ddr2b_ctrl
  import ddr2b_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int LSB_IN = 1,
  localparam int ADDR_W = ROW_W + ((LSB_IN != 0) ? 1 : 0)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lat15Mode,
  input  logic              ldN,
  input  logic              rwN,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrb_t         strb,
  output logic [ROW_W-1:0]  rdRow,
  output logic              rdLsb,
  output logic [ROW_W-1:0]  wrRow,
  output logic              wrLsb
);
  logic             cmdRead, cmdWrite;
  logic [ROW_W-1:0] rowIn;
  logic             lsbIn;
  logic             wrPend, rdS1, rdS2;

  assign cmdRead  = !ldN &&  rwN;
  assign cmdWrite = !ldN && !rwN;

  // Burst start bit: taken from the address, or forced even
  generate
    if (LSB_IN != 0) begin : g_lsbIn
      assign rowIn = addr[ADDR_W-1:1];
      assign lsbIn = addr[0];
    end else begin : g_evenStart
      assign rowIn = addr;
      assign lsbIn = 1'b0;
    end
  endgenerate

  assign rdRow = rowIn;
  assign rdLsb = lsbIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPend <= 1'b0;
      wrRow  <= '0;
      wrLsb  <= 1'b0;
      rdS1   <= 1'b0;
      rdS2   <= 1'b0;
    end else begin
      wrPend <= cmdWrite;
      if (cmdWrite) begin
        wrRow <= rowIn;
        wrLsb <= lsbIn;
      end
      rdS1 <= cmdRead;
      rdS2 <= rdS1;
    end
  end

  always_comb begin
    strb.rdLook    = cmdRead;
    strb.wrCapture = wrPend;
    if (lat15Mode) begin
      strb.evenSrc = rdS2 ? SRC_PREV_W1 : SRC_NONE;
      strb.oddSrc  = rdS1 ? SRC_CUR_W0  : SRC_NONE;
    end else begin
      strb.evenSrc = rdS1 ? SRC_CUR_W0  : SRC_NONE;
      strb.oddSrc  = rdS1 ? SRC_CUR_W1  : SRC_NONE;
    end
  end

  // R2: one-cycle mode fills both slots in the next cycle
  p_read_l1_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && !lat15Mode) |=> (strb.evenSrc == SRC_CUR_W0 && strb.oddSrc == SRC_CUR_W1));

  // R3: 1.5-cycle mode fills the odd slot next cycle and the even slot after
  p_read_l15_odd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && lat15Mode) |=> (strb.oddSrc == SRC_CUR_W0));
  p_read_l15_even_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && lat15Mode) |=> ##1 (strb.evenSrc == SRC_PREV_W1));

  // R5: a write command is always followed by its data cycle
  p_write_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |=> strb.wrCapture);

  // R10: an odd-slot word only follows a read command
  p_no_stray_word_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.oddSrc != SRC_NONE) |-> $past(cmdRead));
endmodule

// File: rtl/ddr2b_datapath.sv
`timescale 1ns/1ps
module ddr2b_datapath
  import ddr2b_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9,
  parameter int ROW_W  = 8,
  localparam int NBYTE = WORD_W / BYTE_W,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ROW_W-1:0]  rdRow,
  input  logic              rdLsb,
  input  logic [ROW_W-1:0]  wrRow,
  input  logic              wrLsb,
  input  logic [WORD_W-1:0] dEven,
  input  logic [WORD_W-1:0] dOdd,
  input  logic [NBYTE-1:0]  bwEvenN,
  input  logic [NBYTE-1:0]  bwOddN,
  output logic [WORD_W-1:0] qEven,
  output logic [WORD_W-1:0] qOdd,
  output logic              qEvenValid,
  output logic              qOddValid
);
  // Storage: both banks of a row packed together, index = bank
  logic [1:0][WORD_W-1:0] memRow [DEPTH];

  // Posted-write register
  logic                   holdValid;
  logic [ROW_W-1:0]       holdRow;
  logic [1:0][WORD_W-1:0] holdData;
  logic [1:0][NBYTE-1:0]  holdMask;

  // Incoming write, routed by bank
  logic [1:0][WORD_W-1:0] inData;
  logic [1:0][NBYTE-1:0]  inMask;
  logic [1:0][WORD_W-1:0] look;
  logic [WORD_W-1:0]      rdW0, rdW1, rdW1d;

  assign inData[0] = wrLsb ? dOdd  : dEven;
  assign inData[1] = wrLsb ? dEven : dOdd;
  assign inMask[0] = wrLsb ? ~bwOddN  : ~bwEvenN;
  assign inMask[1] = wrLsb ? ~bwEvenN : ~bwOddN;

  // Per-byte lookup: live write data, then posted data, then the array
  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        logic fwdLive, fwdHold;
        assign fwdLive = strb.wrCapture && (wrRow == rdRow) && inMask[b][k];
        assign fwdHold = holdValid && (holdRow == rdRow) && holdMask[b][k];
        assign look[b][k*BYTE_W +: BYTE_W] =
          fwdLive ? inData[b][k*BYTE_W +: BYTE_W] :
          fwdHold ? holdData[b][k*BYTE_W +: BYTE_W] :
                    memRow[rdRow][b][k*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memRow[i] <= '0;
      holdValid <= 1'b0;
      holdRow   <= '0;
      holdData  <= '0;
      holdMask  <= '0;
      rdW0      <= '0;
      rdW1      <= '0;
      rdW1d     <= '0;
    end else begin
      if (strb.wrCapture) begin
        if (holdValid) begin
          for (int b = 0; b < 2; b++)
            for (int k = 0; k < NBYTE; k++)
              if (holdMask[b][k])
                memRow[holdRow][b][k*BYTE_W +: BYTE_W] <= holdData[b][k*BYTE_W +: BYTE_W];
        end
        holdValid <= 1'b1;
        holdRow   <= wrRow;
        holdData  <= inData;
        holdMask  <= inMask;
      end
      if (strb.rdLook) begin
        rdW0 <= look[rdLsb];
        rdW1 <= look[~rdLsb];
      end
      rdW1d <= rdW1;
    end
  end

  always_comb begin
    case (strb.evenSrc)
      SRC_CUR_W0:  qEven = rdW0;
      SRC_PREV_W1: qEven = rdW1d;
      default:     qEven = '0;
    endcase
    case (strb.oddSrc)
      SRC_CUR_W0:  qOdd = rdW0;
      SRC_CUR_W1:  qOdd = rdW1;
      default:     qOdd = '0;
    endcase
  end
  assign qEvenValid = (strb.evenSrc != SRC_NONE);
  assign qOddValid  = (strb.oddSrc  != SRC_NONE);

  // R9: once a write has been posted, the register never empties
  p_hold_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(holdValid) |-> holdValid);

  // R9: the posted row moves only in a data-capture cycle
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCapture |=> $stable(holdRow));
endmodule

// File: rtl/ddr2b_sram.sv
`timescale 1ns/1ps
module ddr2b_sram
  import ddr2b_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9,
  parameter int ROW_W  = 8,
  parameter int LSB_IN = 1,
  localparam int NBYTE  = WORD_W / BYTE_W,
  localparam int ADDR_W = ROW_W + ((LSB_IN != 0) ? 1 : 0)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lat15Mode,
  input  logic              ldN,
  input  logic              rwN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dEven,
  input  logic [WORD_W-1:0] dOdd,
  input  logic [NBYTE-1:0]  bwEvenN,
  input  logic [NBYTE-1:0]  bwOddN,
  output logic [WORD_W-1:0] qEven,
  output logic [WORD_W-1:0] qOdd,
  output logic              qEvenValid,
  output logic              qOddValid
);
  ctrlStrb_t        strb;
  logic [ROW_W-1:0] rdRow, wrRow;
  logic             rdLsb, wrLsb;

  ddr2b_ctrl #(.ROW_W(ROW_W), .LSB_IN(LSB_IN)) uCtrl (
    .clk(clk), .rstN(rstN), .lat15Mode(lat15Mode), .ldN(ldN), .rwN(rwN),
    .addr(addr), .strb(strb), .rdRow(rdRow), .rdLsb(rdLsb),
    .wrRow(wrRow), .wrLsb(wrLsb)
  );

  ddr2b_datapath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .ROW_W(ROW_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rdRow(rdRow), .rdLsb(rdLsb),
    .wrRow(wrRow), .wrLsb(wrLsb), .dEven(dEven), .dOdd(dOdd),
    .bwEvenN(bwEvenN), .bwOddN(bwOddN), .qEven(qEven), .qOdd(qOdd),
    .qEvenValid(qEvenValid), .qOddValid(qOddValid)
  );
endmodule

// File: tb/sim_ddr2b_sram.sv
`timescale 1ns/1ps
module sim_ddr2b_sram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lat15 = 1'b0;
  logic        ldN = 1'b1, rwN = 1'b1;
  logic [8:0]  addr = '0;
  logic [17:0] dEven = '0, dOdd = '0;
  logic [1:0]  bwEvenN = 2'b11, bwOddN = 2'b11;
  logic [17:0] qEven, qOdd, q1Even, q1Odd;
  logic        qEvenValid, qOddValid, q1EvenValid, q1OddValid;

  int nChk = 0, nFail = 0;
  logic [17:0] refM [2][256];
  logic [17:0] sE, sO, s1E, s1O;
  logic        sVE, sVO;

  always #4 clk = ~clk;

  ddr2b_sram u0 (
    .clk(clk), .rstN(rstN), .lat15Mode(lat15), .ldN(ldN), .rwN(rwN), .addr(addr),
    .dEven(dEven), .dOdd(dOdd), .bwEvenN(bwEvenN), .bwOddN(bwOddN),
    .qEven(qEven), .qOdd(qOdd), .qEvenValid(qEvenValid), .qOddValid(qOddValid));

  // Narrow variant: burst always starts on the even bank (R7)
  ddr2b_sram #(.LSB_IN(0)) u1 (
    .clk(clk), .rstN(rstN), .lat15Mode(lat15), .ldN(ldN), .rwN(rwN), .addr(addr[8:1]),
    .dEven(dEven), .dOdd(dOdd), .bwEvenN(bwEvenN), .bwOddN(bwOddN),
    .qEven(q1Even), .qOdd(q1Odd), .qEvenValid(q1EvenValid), .qOddValid(q1OddValid));

  task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Apply one cycle of inputs, then sample that cycle's outputs
  task automatic tick(input logic l, input logic r, input logic [8:0] a,
                      input logic [17:0] de, input logic [17:0] dd,
                      input logic [1:0] be, input logic [1:0] bd);
    @(posedge clk); #1;
    ldN = l; rwN = r; addr = a; dEven = de; dOdd = dd; bwEvenN = be; bwOddN = bd;
    #1;
    sE = qEven; sO = qOdd; sVE = qEvenValid; sVO = qOddValid; s1E = q1Even; s1O = q1Odd;
  endtask

  task automatic nop(); tick(1'b1, 1'b1, 9'd0, 18'd0, 18'd0, 2'b11, 2'b11); endtask

  function automatic logic [17:0] mergeW(input logic [17:0] old, input logic [17:0] nw,
                                         input logic [1:0] bwN);
    logic [17:0] r = old;
    if (!bwN[0]) r[8:0]  = nw[8:0];
    if (!bwN[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  task automatic modelWrite(input logic [8:0] a, input logic [17:0] w0, input logic [17:0] w1,
                            input logic [1:0] b0N, input logic [1:0] b1N);
    refM[a[0]][a[8:1]]  = mergeW(refM[a[0]][a[8:1]], w0, b0N);
    refM[!a[0]][a[8:1]] = mergeW(refM[!a[0]][a[8:1]], w1, b1N);
  endtask

  task automatic writeOne(input logic [8:0] a, input logic [17:0] w0, input logic [17:0] w1,
                          input logic [1:0] b0N, input logic [1:0] b1N);
    tick(1'b0, 1'b0, a, 18'd0, 18'd0, 2'b11, 2'b11);
    tick(1'b1, 1'b1, 9'd0, w0, w1, b0N, b1N);
    modelWrite(a, w0, w1, b0N, b1N);
  endtask

  // One-cycle-latency read and compare against the model
  task automatic readL1(input logic [8:0] a, input string tag);
    tick(1'b0, 1'b1, a, 18'd0, 18'd0, 2'b11, 2'b11);
    nop();
    chk({tag, " even valid"}, {17'd0, sVE}, 18'd1);
    chk({tag, " odd valid"},  {17'd0, sVO}, 18'd1);
    chk({tag, " word0"}, sE, refM[a[0]][a[8:1]]);
    chk({tag, " word1"}, sO, refM[!a[0]][a[8:1]]);
  endtask

  task automatic tReset();
    #1;
    chk("R10 reset even data", qEven, 18'd0);
    chk("R10 reset odd valid", {17'd0, qOddValid}, 18'd0);
    readL1(9'd10, "R10 array zero");
  endtask

  task automatic tBasic();
    writeOne(9'd6, 18'h2A5A5, 18'h15A5A, 2'b00, 2'b00);
    nop();
    readL1(9'd6, "R1 R2 R5 basic");
  endtask

  task automatic tWrap();
    readL1(9'd7, "R6 wrap from odd start");
    writeOne(9'd9, 18'h11111, 18'h22222, 2'b00, 2'b00);
    readL1(9'd8, "R6 odd-start write read from even");
  endtask

  task automatic tByteMask();
    writeOne(9'd20, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00);
    writeOne(9'd20, 18'h00000, 18'h00000, 2'b10, 2'b01);
    readL1(9'd20, "R8 R9 partial bytes from posted register");
    writeOne(9'd40, 18'h00001, 18'h00002, 2'b00, 2'b00); // commits row 10
    readL1(9'd20, "R8 partial bytes from array");
  endtask

  task automatic tForward();
    writeOne(9'd30, 18'h0AAAA, 18'h05555, 2'b00, 2'b00);
    tick(1'b0, 1'b0, 9'd30, 18'd0, 18'd0, 2'b11, 2'b11);
    tick(1'b0, 1'b1, 9'd30, 18'h12345, 18'h2BCDE, 2'b01, 2'b00); // read while data arrives
    modelWrite(9'd30, 18'h12345, 18'h2BCDE, 2'b01, 2'b00);
    nop();
    chk("R9 live forward word0", sE, refM[0][15]);
    chk("R9 live forward word1", sO, refM[1][15]);
    readL1(9'd31, "R9 posted forward odd start");
  endtask

  task automatic tNop();
    tick(1'b1, 1'b0, 9'd6, 18'd0, 18'd0, 2'b11, 2'b11);
    tick(1'b1, 1'b1, 9'd6, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00);
    chk("R1 R10 idle even valid", {17'd0, sVE}, 18'd0);
    chk("R1 R10 idle odd data", sO, 18'd0);
    nop();
    readL1(9'd6, "R1 no write when load high");
  endtask

  task automatic tLat15();
    nop(); lat15 = 1'b1; nop();
    tick(1'b0, 1'b1, 9'd6, 18'd0, 18'd0, 2'b11, 2'b11);
    tick(1'b0, 1'b1, 9'd9, 18'd0, 18'd0, 2'b11, 2'b11);
    chk("R3 t+1 odd word0", sO, refM[0][3]);
    chk("R3 t+1 odd valid", {17'd0, sVO}, 18'd1);
    chk("R3 t+1 even idle", {17'd0, sVE}, 18'd0);
    nop();
    chk("R3 R4 t+2 even word1", sE, refM[1][3]);
    chk("R4 overlap odd word0 of second", sO, refM[1][4]);
    chk("R4 overlap both valid", {16'd0, sVE, sVO}, 18'd3);
    nop();
    chk("R4 second word1", sE, refM[0][4]);
    chk("R4 tail odd idle", {17'd0, sVO}, 18'd0);
    nop();
    chk("R10 drained", {16'd0, sVE, sVO}, 18'd0);
    lat15 = 1'b0; nop();
  endtask

  task automatic tB2bL1();
    tick(1'b0, 1'b1, 9'd20, 18'd0, 18'd0, 2'b11, 2'b11);
    tick(1'b0, 1'b1, 9'd30, 18'd0, 18'd0, 2'b11, 2'b11);
    chk("R4 L1 first word0", sE, refM[0][10]);
    chk("R4 L1 first word1", sO, refM[1][10]);
    nop();
    chk("R4 L1 second word0", sE, refM[0][15]);
    chk("R4 L1 second word1", sO, refM[1][15]);
    nop();
    chk("R10 L1 drained", {16'd0, sVE, sVO}, 18'd0);
  endtask

  task automatic tNarrow();
    writeOne(9'd101, 18'h0C0DE, 18'h0BEEF, 2'b00, 2'b00); // odd start: row 50
    tick(1'b0, 1'b1, 9'd100, 18'd0, 18'd0, 2'b11, 2'b11);
    nop();
    chk("R6 wide start uses lsb", sE, 18'h0BEEF);
    chk("R7 narrow word0 even bank", s1E, 18'h0C0DE);
    chk("R7 narrow word1 odd bank", s1O, 18'h0BEEF);
  endtask

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 256; i++) refM[b][i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tBasic();
    tWrap();
    tByteMask();
    tForward();
    tNop();
    tLat15();
    tB2bL1();
    tNarrow();
    repeat (2) nop();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule